// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the protocol side of a serial non-volatile memory that answers on a two-wire bus. It samples the bus clock and data lines with the system clock, finds start and stop conditions, and receives the device-select byte. It compares that byte with the board-strapped select pins, acknowledges or stays silent, and then steps through the byte flow of writes, current-address reads, random reads and sequential reads. The data line is only ever pulled low, through an active-high drive-low enable that feeds an open-drain pad.

The storage array, the word address counter and the self-timed programming timer are outside the block. The engine reaches them through one-cycle strobes. It loads the counter with a full address, writes a byte at the counter, and asks for the byte at the counter; after each of those accesses the counter advances. It also signals the timer to commit a finished write and reads back its busy flag. A size parameter picks one of four capacities, and that choice decides how many select bits are matched against the pins and how many become upper address bits.

The system clock must run at least eight times the bus clock rate. Both bus lines pass through a two-flop synchronizer before any edge is detected.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset the engine is in standby: sdaDrvLow is 0 and memAddrLoad, memWrStrobe, memRdStrobe and memCommit are all 0.
- R2: A start is SDA falling while SCL is high. A following select byte with 1010 in bits [7:4], matching select bits and bit [0] as read/write (1 = read) is acknowledged. The engine acknowledges by pulling SDA low through the ninth SCL pulse.
- R3: If the prefix differs or any compared select bit differs from its pin, the engine gives no acknowledge. It then returns to standby and raises no memory strobe until the next start.
- R4: With MEM_KBITS = 8 (the default), only select bit [3] is compared, with devPins[2]. Select bits [2:1] are ignored for matching and become memAddr[9:8] when the word address is loaded, with the word byte in memAddr[7:0]. With 2 all three select bits are compared, with 4 two are compared, and with 16 none are compared.
- R5: In a write, the word address byte is acknowledged and gives one memAddrLoad pulse. Each data byte after it is acknowledged and gives one memWrStrobe pulse with the byte on memWrData. Each pulse lands while SCL is low.
- R6: After a read select byte is acknowledged, the engine sends the byte on memRdData MSB first. SDA changes only while SCL is low. There is one memRdStrobe per byte sent, so a read continues from the address counter, including a current-address read.
- R7: A read goes on byte after byte while the master acknowledges. After a missing acknowledge the engine releases SDA and raises no further memRdStrobe.
- R8: A stop (SDA rising while SCL high) gives one memCommit pulse only if at least one data byte was written since the last start. A stop after a read or after an address-only transfer gives none.
- R9: While memBusy is high, a select byte is not acknowledged.
- R10: A start at any point, including mid-byte, abandons the transfer in progress and restarts reception of the select byte.
- R11: A repeated start after the word address, followed by a read select byte, turns the transfer into a random read from the loaded address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line, asynchronous |
| sdaIn | input | 1 | Bus data line as seen on the wire, asynchronous |
| devPins | input | 3 | Strapped select pins, bit 2 is the most significant |
| memBusy | input | 1 | High while the external programming timer runs |
| memRdData | input | 8 | Byte stored at the external address counter |
| sdaDrvLow | output | 1 | Open-drain enable; 1 pulls SDA low |
| memAddrLoad | output | 1 | Load the external counter with memAddr |
| memAddr | output | ADDR_W | Full word address for a load |
| memWrStrobe | output | 1 | Write memWrData at the counter, then advance within the page |
| memWrData | output | 8 | Byte to write |
| memRdStrobe | output | 1 | Byte at the counter consumed; advance the counter |
| memCommit | output | 1 | Start the programming cycle for the buffered write |

## Verification
If the engine loses its place in the bit count, the fault reaches the bus within one byte. The acknowledge then shows up in the wrong SCL pulse, or a read byte comes back shifted, and the master sees that on the next sample. If the select decode is wrong, the fault is visible at once in the ninth pulse of the select byte, as a missing or false acknowledge. A wrong upper-address split appears at the memAddr value of the next load, and it also corrupts read-back data. A lost or spurious write flag shows as an extra or missing memCommit at the next stop.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_ACK_DEV, ST_WADDR, ST_ACK_WADDR,
    ST_WDATA, ST_ACK_WDATA, ST_RDATA, ST_RACK
  } engState_t;

  typedef struct packed {
    logic clrBits;
    logic shiftIn;
    logic shiftOut;
    logic loadTx;
    logic latchSel;
  } dpCtrl_t;

  localparam logic [3:0] DEV_PREFIX = 4'b1010;
endpackage

// File: rtl/twi_mem_datapath.sv
module twi_mem_datapath
  import twi_mem_pkg::*;
#(
  parameter int MEM_KBITS = 8,
  localparam int PAGE_BITS = $clog2(MEM_KBITS) - 1,
  localparam int ADDR_W = 8 + PAGE_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [2:0]        devPins,
  input  logic [7:0]        memRdData,
  input  dpCtrl_t           ctl,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic              sdaNow,
  output logic [3:0]        bitCnt,
  output logic              devMatch,
  output logic              rwBit,
  output logic              txBit,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWrData
);
  localparam logic [2:0] CMP_MASK = 3'(7 << PAGE_BITS);

  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev;
  logic [7:0] shiftReg, txReg;
  logic [2:0] selReg;
  logic [10:0] fullAddr;

  // two-flop synchronizers plus one history stage for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  assign sdaNow   = sdaSync[1];
  assign sclRise  = sclSync[1] & ~sclPrev;
  assign sclFall  = ~sclSync[1] & sclPrev;
  assign startDet = sclSync[1] & sclPrev & sdaPrev & ~sdaSync[1];
  assign stopDet  = sclSync[1] & sclPrev & ~sdaPrev & sdaSync[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftReg <= '0;
      txReg    <= '1;
      selReg   <= '0;
    end else begin
      if (ctl.clrBits)                    bitCnt <= '0;
      else if (ctl.shiftIn | ctl.shiftOut) bitCnt <= bitCnt + 4'd1;
      if (ctl.shiftIn) shiftReg <= {shiftReg[6:0], sdaSync[1]};
      if (ctl.loadTx)        txReg <= memRdData;
      else if (ctl.shiftOut) txReg <= {txReg[6:0], 1'b1};
      if (ctl.latchSel) selReg <= shiftReg[3:1];
    end
  end

  assign devMatch  = (shiftReg[7:4] == DEV_PREFIX) &&
                     (((shiftReg[3:1] ^ devPins) & CMP_MASK) == 3'b000);
  assign rwBit     = shiftReg[0];
  assign txBit     = txReg[7];
  assign fullAddr  = {selReg, shiftReg};
  assign memAddr   = fullAddr[ADDR_W-1:0];
  assign memWrData = shiftReg;
endmodule

// File: rtl/twi_mem_ctrl.sv
module twi_mem_ctrl
  import twi_mem_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic       sdaNow,
  input  logic [3:0] bitCnt,
  input  logic       devMatch,
  input  logic       rwBit,
  input  logic       txBit,
  input  logic       memBusy,
  output dpCtrl_t    ctl,
  output logic       sdaDrvLow,
  output logic       memAddrLoad,
  output logic       memWrStrobe,
  output logic       memRdStrobe,
  output logic       memCommit
);
  engState_t state, nextState;
  logic wrPending, ackSeen;

  always_comb begin
    nextState   = state;
    ctl         = '0;
    memAddrLoad = 1'b0;
    memWrStrobe = 1'b0;
    memRdStrobe = 1'b0;
    memCommit   = 1'b0;
    if (startDet) begin
      nextState   = ST_DEV;
      ctl.clrBits = 1'b1;
    end else if (stopDet) begin
      nextState = ST_IDLE;
      memCommit = wrPending;
    end else begin
      case (state)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (sclRise && bitCnt < 4'd8) ctl.shiftIn = 1'b1;
          else if (sclFall && bitCnt == 4'd8) begin
            if (state == ST_DEV) begin
              if (devMatch && !memBusy) begin
                nextState    = ST_ACK_DEV;
                ctl.latchSel = 1'b1;
              end else nextState = ST_IDLE;
            end else if (state == ST_WADDR) begin
              nextState   = ST_ACK_WADDR;
              memAddrLoad = 1'b1;
            end else begin
              nextState   = ST_ACK_WDATA;
              memWrStrobe = 1'b1;
            end
          end
        end
        ST_ACK_DEV: if (sclFall) begin
          ctl.clrBits = 1'b1;
          if (rwBit) begin
            nextState   = ST_RDATA;
            ctl.loadTx  = 1'b1;
            memRdStrobe = 1'b1;
          end else nextState = ST_WADDR;
        end
        ST_ACK_WADDR, ST_ACK_WDATA: if (sclFall) begin
          ctl.clrBits = 1'b1;
          nextState   = ST_WDATA;
        end
        ST_RDATA: if (sclFall) begin
          if (bitCnt == 4'd7) nextState = ST_RACK;
          else ctl.shiftOut = 1'b1;
        end
        ST_RACK: if (sclFall) begin
          if (ackSeen) begin
            nextState   = ST_RDATA;
            ctl.clrBits = 1'b1;
            ctl.loadTx  = 1'b1;
            memRdStrobe = 1'b1;
          end else nextState = ST_IDLE;
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      wrPending <= 1'b0;
      ackSeen   <= 1'b0;
    end else begin
      state <= nextState;
      if (startDet || stopDet) wrPending <= 1'b0;
      else if (memWrStrobe)   wrPending <= 1'b1;
      if (state == ST_RACK && sclRise) ackSeen <= ~sdaNow;
    end
  end

  assign sdaDrvLow = (state == ST_ACK_DEV) || (state == ST_ACK_WADDR) ||
                     (state == ST_ACK_WDATA) || (state == ST_RDATA && !txBit);
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
  import twi_mem_pkg::*;
#(
  parameter int MEM_KBITS = 8,
  localparam int PAGE_BITS = $clog2(MEM_KBITS) - 1,
  localparam int ADDR_W = 8 + PAGE_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [2:0]        devPins,
  input  logic              memBusy,
  input  logic [7:0]        memRdData,
  output logic              sdaDrvLow,
  output logic              memAddrLoad,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrStrobe,
  output logic [7:0]        memWrData,
  output logic              memRdStrobe,
  output logic              memCommit
);
  dpCtrl_t    ctl;
  logic       sclRise, sclFall, startDet, stopDet, sdaNow;
  logic [3:0] bitCnt;
  logic       devMatch, rwBit, txBit;

  twi_mem_datapath #(.MEM_KBITS(MEM_KBITS)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .devPins(devPins),
    .memRdData(memRdData), .ctl(ctl), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaNow(sdaNow), .bitCnt(bitCnt),
    .devMatch(devMatch), .rwBit(rwBit), .txBit(txBit), .memAddr(memAddr),
    .memWrData(memWrData)
  );

  twi_mem_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaNow(sdaNow), .bitCnt(bitCnt),
    .devMatch(devMatch), .rwBit(rwBit), .txBit(txBit), .memBusy(memBusy),
    .ctl(ctl), .sdaDrvLow(sdaDrvLow), .memAddrLoad(memAddrLoad),
    .memWrStrobe(memWrStrobe), .memRdStrobe(memRdStrobe), .memCommit(memCommit)
  );
endmodule

// File: rtl/twi_mem_chk.sv
module twi_mem_chk (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sdaIn,
  input logic sdaDrvLow,
  input logic memAddrLoad,
  input logic memWrStrobe,
  input logic memRdStrobe,
  input logic memCommit
);
  p_sda_change_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sdaDrvLow != $past(sdaDrvLow)) |-> !sclIn);
  p_load_on_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    memAddrLoad |-> !sclIn);
  p_wr_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    memWrStrobe |=> !memWrStrobe);
  p_rd_on_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    memRdStrobe |-> !sclIn);
  p_commit_at_stop_r8: assert property (@(posedge clk) disable iff (!rstN)
    memCommit |-> (sclIn && sdaIn));
  p_commit_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    memCommit |=> !memCommit);
endmodule

bind twi_mem_slave twi_mem_chk u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .sdaDrvLow(sdaDrvLow),
  .memAddrLoad(memAddrLoad), .memWrStrobe(memWrStrobe),
  .memRdStrobe(memRdStrobe), .memCommit(memCommit)
);

// File: tb/tb_twi_mem_slave.sv
module tb_twi_mem_slave;
  localparam int Q = 4;
  localparam logic [2:0] PINS = 3'b101;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic memBusy = 1'b0;
  logic [7:0] memRdData;
  logic sdaDrvLow, memAddrLoad, memWrStrobe, memRdStrobe, memCommit;
  logic [9:0] memAddr;
  logic [7:0] memWrData;
  logic sdaBus;

  always #2.5 clk = ~clk;
  assign sdaBus = sdaM & ~sdaDrvLow;

  twi_mem_slave dut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus), .devPins(PINS),
    .memBusy(memBusy), .memRdData(memRdData), .sdaDrvLow(sdaDrvLow),
    .memAddrLoad(memAddrLoad), .memAddr(memAddr), .memWrStrobe(memWrStrobe),
    .memWrData(memWrData), .memRdStrobe(memRdStrobe), .memCommit(memCommit)
  );

  // external array and address counter
  logic [7:0] envMem [1024];
  logic [9:0] ptr;
  assign memRdData = envMem[ptr];
  always @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
      for (int i = 0; i < 1024; i++) envMem[i] <= 8'h00;
    end else begin
      if (memAddrLoad) ptr <= memAddr;
      if (memWrStrobe) begin
        envMem[ptr] <= memWrData;
        ptr <= {ptr[9:4], ptr[3:0] + 4'd1};
      end
      if (memRdStrobe) ptr <= ptr + 10'd1;
    end
  end

  int commitCnt = 0, rdCnt = 0, wrCnt = 0, loadCnt = 0;
  logic [9:0] lastLoad = '0;
  always @(negedge clk) begin
    if (memAddrLoad) begin lastLoad = memAddr; loadCnt++; end
    if (memCommit) commitCnt++;
    if (memRdStrobe) rdCnt++;
    if (memWrStrobe) wrCnt++;
  end

  logic [7:0] gold [1024];
  logic [7:0] wbuf [32];
  int checks = 0, fails = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic waitQ(); repeat (Q) @(negedge clk); endtask
  task automatic startCond();
    sdaM = 1'b1; waitQ(); scl = 1'b1; waitQ(); sdaM = 1'b0; waitQ(); scl = 1'b0; waitQ();
  endtask
  task automatic stopCond();
    sdaM = 1'b0; waitQ(); scl = 1'b1; waitQ(); sdaM = 1'b1; waitQ(); waitQ();
  endtask
  task automatic sendBit(input bit b);
    sdaM = b; waitQ(); scl = 1'b1; waitQ(); waitQ(); scl = 1'b0; waitQ();
  endtask
  task automatic recvBit(output bit b);
    sdaM = 1'b1; waitQ(); scl = 1'b1; waitQ(); b = sdaBus; waitQ(); scl = 1'b0; waitQ();
  endtask
  task automatic sendByte(input logic [7:0] v, output bit acked);
    bit r;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    recvBit(r);
    acked = !r;
  endtask
  task automatic recvByte(input bit giveAck, output logic [7:0] v);
    bit r;
    for (int i = 7; i >= 0; i--) begin recvBit(r); v[i] = r; end
    sendBit(!giveAck);
  endtask

  function automatic logic [7:0] devByte(input logic [1:0] pg, input bit rd);
    return {4'b1010, PINS[2], pg, rd};
  endfunction

  task automatic pageWrite(input logic [1:0] pg, input logic [7:0] word, input int n);
    bit a;
    int wb = wrCnt;
    int cb = commitCnt;
    startCond();
    sendByte(devByte(pg, 1'b0), a);
    check(a, "R2", "select ack on write", int'(a), 1);
    sendByte(word, a);
    check(a, "R5", "word address ack", int'(a), 1);
    check(lastLoad == {pg, word}, "R4", "loaded address", int'(lastLoad), int'({pg, word}));
    for (int i = 0; i < n; i++) begin
      sendByte(wbuf[i], a);
      check(a, "R5", "data byte ack", int'(a), 1);
      gold[{pg, word[7:4], 4'(word[3:0] + 4'(i))}] = wbuf[i];
    end
    stopCond();
    repeat (4) @(negedge clk);
    check(wrCnt - wb == n, "R5", "write strobe count", wrCnt - wb, n);
    check(commitCnt - cb == 1, "R8", "commit after write stop", commitCnt - cb, 1);
  endtask

  task automatic randRead(input logic [1:0] pg, input logic [7:0] word, input int n);
    bit a;
    bit anyDrive;
    logic [7:0] v;
    logic [9:0] ad;
    int rb, cb;
    startCond();
    sendByte(devByte(pg, 1'b0), a);
    check(a, "R11", "dummy write select ack", int'(a), 1);
    sendByte(word, a);
    check(a, "R11", "dummy word ack", int'(a), 1);
    rb = rdCnt;
    cb = commitCnt;
    startCond();
    sendByte(devByte(pg, 1'b1), a);
    check(a, "R2", "select ack on read", int'(a), 1);
    for (int i = 0; i < n; i++) begin
      recvByte(i < n - 1, v);
      ad = {pg, word} + 10'(i);
      check(v == gold[ad], "R11", "read data", int'(v), int'(gold[ad]));
    end
    anyDrive = 1'b0;
    repeat (12) begin @(negedge clk); anyDrive |= sdaDrvLow; end
    check(!anyDrive, "R7", "SDA released after master nack", int'(anyDrive), 0);
    stopCond();
    repeat (4) @(negedge clk);
    check(rdCnt - rb == n, "R7", "read strobe count", rdCnt - rb, n);
    check(commitCnt == cb, "R8", "no commit after read", commitCnt - cb, 0);
  endtask

  task automatic currentRead(input logic [9:0] expAddr);
    bit a;
    logic [7:0] v;
    startCond();
    sendByte(devByte(2'b11, 1'b1), a);
    check(a, "R6", "current read select ack", int'(a), 1);
    recvByte(1'b0, v);
    check(v == gold[expAddr], "R6", "current address data", int'(v), int'(gold[expAddr]));
    stopCond();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit a;
    int lc, wc, cb;
    logic [1:0] pg;
    logic [7:0] wd;
    int n;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) gold[i] = 8'h00;
    repeat (6) @(negedge clk);
    check(sdaDrvLow == 0 && !memAddrLoad && !memWrStrobe && !memRdStrobe && !memCommit,
          "R1", "outputs in reset", int'(sdaDrvLow), 0);
    rstN = 1'b1;
    repeat (6) @(negedge clk);
    check(sdaDrvLow == 0, "R1", "standby after reset", int'(sdaDrvLow), 0);

    // R3: compared select bit mismatch and wrong prefix
    lc = loadCnt; wc = wrCnt;
    startCond();
    sendByte({4'b1010, ~PINS[2], 2'b00, 1'b0}, a);
    check(!a, "R3", "nack on select pin mismatch", int'(a), 0);
    sendByte(8'h12, a);
    check(!a, "R3", "silent after mismatch", int'(a), 0);
    stopCond();
    startCond();
    sendByte({4'b1110, PINS[2], 2'b00, 1'b0}, a);
    check(!a, "R3", "nack on wrong prefix", int'(a), 0);
    stopCond();
    check(loadCnt == lc && wrCnt == wc, "R3", "no strobes after mismatch", loadCnt - lc, 0);

    // R9: busy timer blocks the select acknowledge
    cb = commitCnt;
    memBusy = 1'b1;
    startCond();
    sendByte(devByte(2'b00, 1'b0), a);
    check(!a, "R9", "nack while busy", int'(a), 0);
    stopCond();
    memBusy = 1'b0;
    startCond();
    sendByte(devByte(2'b00, 1'b0), a);
    check(a, "R9", "ack once idle", int'(a), 1);
    stopCond();
    repeat (4) @(negedge clk);
    check(commitCnt == cb, "R8", "no commit without data", commitCnt - cb, 0);

    // R4: page bits differ from pins A1/A0, wrap within page
    for (int i = 0; i < 20; i++) wbuf[i] = 8'(8'hA0 + i);
    pageWrite(2'b10, 8'h3C, 20);
    randRead(2'b10, 8'h30, 16);
    currentRead(10'h240);

    // R10: start in the middle of a word address byte
    startCond();
    sendByte(devByte(2'b01, 1'b0), a);
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);
    wbuf[0] = 8'h5A;
    pageWrite(2'b01, 8'h40, 1);
    randRead(2'b01, 8'h40, 1);
    check(gold[10'h140] == 8'h5A, "R10", "write after abort", int'(gold[10'h140]), 'h5A);

    // R6: sequential read rolls over the top of the array
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    pageWrite(2'b11, 8'hFE, 2);
    wbuf[0] = 8'h33;
    pageWrite(2'b00, 8'h00, 1);
    randRead(2'b11, 8'hFE, 4);

    // random page writes and read-backs
    for (int it = 0; it < 6; it++) begin
      pg = 2'($urandom % 4);
      wd = 8'($urandom % 256);
      n  = 1 + int'($urandom % 18);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      pageWrite(pg, wd, n);
      randRead(pg, {wd[7:4], 4'h0}, 16);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule